// File: doc/BRIEF.md
# Byte-Oriented SPI Slave with Sticky Status Flags

This block is the target side of an SPI link inside a design clocked much faster than the serial clock. The serial clock, data-in and select pins come in asynchronously. Each is passed through a two-stage synchronizer, and edges are then detected in the system clock domain. Eight sampling edges make one byte, shifted MSB first. A byte sent on `miso` is taken from a one-entry holding latch, which the local side fills through a valid/ready port. A received byte lands in a one-entry buffer that the local side drains through a second valid/ready port. The block has four modes, from the two bits `cpol` and `cpha`. It can run with a select pin that gates it and re-aligns its bit count, or in a three-wire mode in which the select pin is ignored.

Both data ports are valid/ready, with these back-pressure rules. On the transmit side, a beat moves when `tx_valid` and `tx_ready` are both high. A cycle in which `tx_valid` is high while `tx_ready` is low does not stall: that beat is dropped and counted as a write collision. A source must therefore wait for `tx_ready` before it raises `tx_valid`, and every cycle with `tx_valid` high is a separate attempt. On the receive side, `rx_valid` stays high while an unread byte waits, and `rx_valid && rx_ready` consumes it. The serial side cannot be held back. A byte that completes while the buffer is still full is lost, and the overrun is recorded.

There are three sticky flags: byte done, write collision and receive overrun. Each flag stays set until its bit on `stat_clr` is pulsed. Together with an enable input, the flags drive the interrupt output.

Top module: `spi_byte_slave`

## Requirements
- R1: After reset, `tx_ready` is 1, `rx_valid` is 0, `stat_flags` is 0, `irq` is 0 and `miso` is 0.
- R2: `cpol` gives the idle level of SCK. With `cpha`=0, MOSI is sampled on the edge leaving idle: rising when `cpol`=0, falling when `cpol`=1. With `cpha`=1, MOSI is sampled on the edge returning to idle. The first bit received is bit 7 of `rx_data`, and the eighth sampling edge completes the byte.
- R3: `miso` shows bit 7 of the loaded byte before the first sampling edge, and moves to the next lower bit after each sampling edge. `miso_oe` is high when the block is enabled and selected. While `miso_oe` is low, `miso` is 0.
- R4: An accepted transmit beat goes into the holding latch. The latch moves into the shift register only when the shift register holds no pending byte and no byte has started. A byte starts at its first leading SCK edge, and from then on the shift register is locked. A beat accepted during a byte waits in the latch and is loaded after that byte ends. With nothing loaded, the block sends 0x00.
- R5: `tx_valid` while `tx_ready` is low sets `stat_flags[1]` (write collision). The beat is dropped and the latch keeps its earlier byte.
- R6: `stat_flags[0]` (byte done) is set when each byte completes.
- R7: If a byte completes while `rx_valid` is high and no read happens in that cycle, `stat_flags[2]` (overrun) is set. The new byte is lost, and `rx_data` keeps the older byte.
- R8: `rx_valid && rx_ready` empties the buffer on the next cycle. If a byte completes in the same cycle as a read, the new byte is stored, `rx_valid` stays high, and no overrun is recorded.
- R9: Flags stay set until the matching `stat_clr` bit is pulsed. If a flag is set and cleared in the same cycle, the set wins. `irq` equals `irq_en` AND (any flag set).
- R10: With `three_wire`=0, SCK edges are ignored while NSS is high, and the bit count is held at zero. After NSS falls, a fresh byte starts and any partial byte is discarded. NSS must fall at least 2 system clocks before the first SCK edge.
- R11: With `three_wire`=1, NSS has no effect. The bit count carries across any NSS activity.
- R12: While `en` is low, SCK edges are ignored and the bit count is cleared. Dropping `en` and raising it again is the only way to re-align a three-wire byte. `cpol`, `cpha` and `three_wire` may change only while `en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Slave enable |
| three_wire | input | 1 | 1: ignore NSS; 0: NSS gates the slave |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| irq_en | input | 1 | Interrupt enable |
| sck | input | 1 | Serial clock (asynchronous) |
| mosi | input | 1 | Serial data in (asynchronous) |
| nss | input | 1 | Select, active low (asynchronous) |
| miso | output | 1 | Serial data out, 0 when not driven |
| miso_oe | output | 1 | Output enable for the MISO pad |
| tx_data | input | 8 | Transmit byte |
| tx_valid | input | 1 | Transmit beat offered |
| tx_ready | output | 1 | Holding latch free |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Unread byte present |
| rx_ready | input | 1 | Consume received byte |
| stat_flags | output | 3 | bit0 done, bit1 collision, bit2 overrun |
| stat_clr | input | 3 | Pulse a bit to clear the matching flag |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties check several rules on every cycle. A colliding beat leaves the latch untouched. The shift register does not move between sampling edges once a byte has started. The bit count is zero while the slave is inactive. A byte that overruns leaves the buffer unchanged. Flags hold until cleared, and mode bits are steady while the slave is enabled. Only the bench scenarios show the byte-level behaviour: the received value in all four modes, MSB-first output, a late beat waiting for the next byte, re-alignment after a select pulse or an enable toggle, and a read landing in the same cycle as a completed byte.

// File: rtl/spi_byte_slave_pkg.sv
`timescale 1ns/1ps
package spi_byte_slave_pkg;
  localparam int NUM_FLAGS = 3;
  localparam int FLAG_DONE = 0;
  localparam int FLAG_WCOL = 1;
  localparam int FLAG_OVR  = 2;

  // synchronized pin bundle
  typedef struct packed {
    logic nss;
    logic mosi;
    logic sck;
  } pins_t;

  localparam pins_t PINS_IDLE = '{nss: 1'b1, mosi: 1'b0, sck: 1'b0};
endpackage

// File: rtl/spi_pin_sync.sv
`timescale 1ns/1ps
module spi_pin_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_shift_core.sv
`timescale 1ns/1ps
module spi_shift_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              three_wire,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              sck_s,
  input  logic              mosi_s,
  input  logic              nss_s,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              miso,
  output logic              miso_oe,
  output logic              byte_done,
  output logic [DATA_W-1:0] byte_val,
  output logic              wcol_evt
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic              sck_q;
  logic              started;
  logic              tx_full;
  logic              sh_full;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] tx_latch;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;

  logic sck_rise, sck_fall, act, lead_e, samp_e, load_sh, wr_ok;

  always_comb begin
    sck_rise  = sck_s & ~sck_q;
    sck_fall  = ~sck_s & sck_q;
    act       = en & (three_wire | ~nss_s);
    lead_e    = act & (cpol ? sck_fall : sck_rise);
    samp_e    = act & ((cpol ^ cpha) ? sck_fall : sck_rise);
    byte_done = samp_e & (bit_cnt == LAST_BIT);
    byte_val  = {rx_sh[DATA_W-2:0], mosi_s};
    load_sh   = ~started & ~lead_e & tx_full & ~sh_full;
    wr_ok     = tx_valid & ~tx_full;
    wcol_evt  = tx_valid & tx_full;
    tx_ready  = ~tx_full;
    miso_oe   = act;
    miso      = act & tx_sh[DATA_W-1];
  end

  // edge history and byte framing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      bit_cnt <= '0;
      started <= 1'b0;
    end else begin
      sck_q <= sck_s;
      if (!act) begin
        bit_cnt <= '0;
        started <= 1'b0;
      end else if (samp_e) begin
        bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
        started <= ~byte_done;
      end else if (lead_e) begin
        started <= 1'b1;
      end
    end
  end

  // holding latch
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_latch <= '0;
      tx_full  <= 1'b0;
    end else if (wr_ok) begin
      tx_latch <= tx_data;
      tx_full  <= 1'b1;
    end else if (load_sh) begin
      tx_full  <= 1'b0;
    end
  end

  // shift registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      sh_full <= 1'b0;
      rx_sh   <= '0;
    end else begin
      if (load_sh) begin
        tx_sh   <= tx_latch;
        sh_full <= 1'b1;
      end else if (samp_e) begin
        if (byte_done) begin
          tx_sh   <= '0;
          sh_full <= 1'b0;
        end else begin
          tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
        end
      end
      if (samp_e) rx_sh <= byte_val;
    end
  end

  p_wcol_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> $stable(tx_latch))
    else $error("colliding beat altered the holding latch");

  p_shift_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !samp_e) |=> $stable(tx_sh))
    else $error("shift register moved inside a started byte");

  p_idle_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> (bit_cnt == '0))
    else $error("bit count not cleared while inactive");

  p_mode_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> $stable({cpol, cpha, three_wire}))
    else $error("mode bits changed while enabled");
endmodule

// File: rtl/spi_rx_buffer.sv
`timescale 1ns/1ps
module spi_rx_buffer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] byte_val,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              ovr_evt
);
  logic              full_q;
  logic [DATA_W-1:0] buf_q;
  logic              rd;

  always_comb begin
    rd       = full_q & rx_ready;
    ovr_evt  = byte_done & full_q & ~rd;
    rx_valid = full_q;
    rx_data  = buf_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      buf_q  <= '0;
    end else if (byte_done && !ovr_evt) begin
      buf_q  <= byte_val;
      full_q <= 1'b1;
    end else if (rd) begin
      full_q <= 1'b0;
    end
  end

  p_overrun_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && full_q && !rx_ready) |=> ($stable(buf_q) && full_q))
    else $error("overrun replaced the unread byte");

  p_read_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !byte_done) |=> !full_q)
    else $error("read did not empty the buffer");
endmodule

// File: rtl/spi_flag_bank.sv
`timescale 1ns/1ps
module spi_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic         irq_en,
  output logic [N-1:0] flags,
  output logic         irq
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      flags[g] <= 1'b0;
      else if (set[g]) flags[g] <= 1'b1;
      else if (clr[g]) flags[g] <= 1'b0;
    end

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[g] && !clr[g]) |=> flags[g])
      else $error("flag dropped without a clear");

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[g] && !set[g]) |=> !flags[g])
      else $error("flag survived its clear");
  end

  assign irq = irq_en & (|flags);
endmodule

// File: rtl/spi_byte_slave.sv
`timescale 1ns/1ps
module spi_byte_slave
  import spi_byte_slave_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 three_wire,
  input  logic                 cpol,
  input  logic                 cpha,
  input  logic                 irq_en,
  input  logic                 sck,
  input  logic                 mosi,
  input  logic                 nss,
  output logic                 miso,
  output logic                 miso_oe,
  input  logic [DATA_W-1:0]    tx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  output logic [DATA_W-1:0]    rx_data,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic [NUM_FLAGS-1:0] stat_flags,
  input  logic [NUM_FLAGS-1:0] stat_clr,
  output logic                 irq
);
  pins_t raw_pins, sync_pins;
  logic                 byte_done, wcol_evt, ovr_evt;
  logic [DATA_W-1:0]    byte_val;
  logic [NUM_FLAGS-1:0] flag_set;

  assign raw_pins = '{nss: nss, mosi: mosi, sck: sck};

  spi_pin_sync #(
    .W($bits(pins_t)), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_pins), .q(sync_pins)
  );

  spi_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .en(en), .three_wire(three_wire),
    .cpol(cpol), .cpha(cpha),
    .sck_s(sync_pins.sck), .mosi_s(sync_pins.mosi), .nss_s(sync_pins.nss),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .miso(miso), .miso_oe(miso_oe),
    .byte_done(byte_done), .byte_val(byte_val), .wcol_evt(wcol_evt)
  );

  spi_rx_buffer #(.DATA_W(DATA_W)) u_rxbuf (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .byte_val(byte_val),
    .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .ovr_evt(ovr_evt)
  );

  always_comb begin
    flag_set            = '0;
    flag_set[FLAG_DONE] = byte_done;
    flag_set[FLAG_WCOL] = wcol_evt;
    flag_set[FLAG_OVR]  = ovr_evt;
  end

  spi_flag_bank #(.N(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(stat_clr),
    .irq_en(irq_en), .flags(stat_flags), .irq(irq)
  );
endmodule

// File: tb/spi_byte_slave_bench.sv
`timescale 1ns/1ps
module spi_byte_slave_bench;
  localparam int H = 8; // system clocks per SCK half period

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, en, three_wire, cpol, cpha, irq_en, sck, mosi, nss;
  logic tx_valid, rx_ready;
  logic [7:0] tx_data;
  logic [2:0] stat_clr;
  logic miso, miso_oe, tx_ready, rx_valid, irq;
  logic [7:0] rx_data;
  logic [2:0] stat_flags;

  spi_byte_slave u_spi_byte_slave (
    .clk(clk), .rst_n(rst_n), .en(en), .three_wire(three_wire),
    .cpol(cpol), .cpha(cpha), .irq_en(irq_en),
    .sck(sck), .mosi(mosi), .nss(nss), .miso(miso), .miso_oe(miso_oe),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .stat_flags(stat_flags), .stat_clr(stat_clr), .irq(irq)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [2:0] m_q1, m_q2;          // {nss,mosi,sck} delayed one and two clocks
  logic       m_prev_sck;
  int         m_bits;
  bit         m_inbyte, m_lat_full, m_sh_full, m_rx_full;
  logic [7:0] m_lat, m_sh, m_rsh, m_rbuf;
  logic [2:0] m_flags;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q1 = 3'b100; m_q2 = 3'b100; m_prev_sck = 0;
      m_bits = 0; m_inbyte = 0; m_lat_full = 0; m_sh_full = 0; m_rx_full = 0;
      m_lat = 0; m_sh = 0; m_rsh = 0; m_rbuf = 0; m_flags = 0;
    end else begin
      bit up, dn, on, lead, samp, fin, ld, rd, wc, ov;
      logic [7:0] nb;
      logic [2:0] setv;
      up = m_q2[0] && !m_prev_sck;
      dn = !m_q2[0] && m_prev_sck;
      on = en && (three_wire || !m_q2[2]);
      if (cpol) lead = on && dn; else lead = on && up;
      if (cpha == 0) samp = lead;
      else if (cpol) samp = on && up;
      else samp = on && dn;
      fin = samp && (m_bits == 7);
      ld  = !m_inbyte && !lead && m_lat_full && !m_sh_full;
      wc  = tx_valid && m_lat_full;
      rd  = m_rx_full && rx_ready;
      nb  = {m_rsh[6:0], m_q2[1]};
      ov  = fin && m_rx_full && !rd;
      setv = {ov, wc, fin};
      m_flags = (m_flags & ~stat_clr) | setv;
      if (fin && !ov) begin m_rbuf = nb; m_rx_full = 1; end
      else if (rd) m_rx_full = 0;
      if (samp) m_rsh = nb;
      if (ld) begin m_sh = m_lat; m_sh_full = 1; end
      else if (fin) begin m_sh = 0; m_sh_full = 0; end
      else if (samp) m_sh = m_sh << 1;
      if (tx_valid && !m_lat_full) begin m_lat = tx_data; m_lat_full = 1; end
      else if (ld) m_lat_full = 0;
      if (!on) begin m_bits = 0; m_inbyte = 0; end
      else if (samp) begin m_bits = fin ? 0 : m_bits + 1; m_inbyte = !fin; end
      else if (lead) m_inbyte = 1;
      m_prev_sck = m_q2[0];
      m_q2 = m_q1;
      m_q1 = {nss, mosi, sck};
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !finished) begin
      bit eon;
      logic eso;
      eon = en && (three_wire || !m_q2[2]);
      eso = eon && m_sh[7];
      vectors++;
      if (tx_ready !== !m_lat_full) begin
        miscompares++; $display("FAIL R4 tx_ready: actual %0b expected %0b", tx_ready, !m_lat_full);
      end else if (rx_valid !== m_rx_full) begin
        miscompares++; $display("FAIL R8 rx_valid: actual %0b expected %0b", rx_valid, m_rx_full);
      end else if (m_rx_full && rx_data !== m_rbuf) begin
        miscompares++; $display("FAIL R2 rx_data: actual %0h expected %0h", rx_data, m_rbuf);
      end else if (stat_flags !== m_flags) begin
        miscompares++; $display("FAIL R9 flags: actual %0b expected %0b", stat_flags, m_flags);
      end else if (irq !== (irq_en && |m_flags)) begin
        miscompares++; $display("FAIL R9 irq: actual %0b expected %0b", irq, irq_en && |m_flags);
      end else if (miso_oe !== eon || miso !== eso) begin
        miscompares++; $display("FAIL R3 miso/oe: actual %0b%0b expected %0b%0b", miso_oe, miso, eon, eso);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input bit tw, input bit p, input bit h);
    en = 0; ticks(1);
    three_wire = tw; cpol = p; cpha = h; sck = p; nss = 1;
    ticks(5);
    en = 1; ticks(3);
  endtask

  task automatic spi_bit(input logic b, output logic o);
    if (!cpha) begin
      mosi = b; ticks(H);
      o = miso; sck = ~cpol; ticks(H);
      sck = cpol;
    end else begin
      ticks(H);
      sck = ~cpol; mosi = b; ticks(H);
      o = miso; sck = cpol;
    end
  endtask

  task automatic spi_byte(input logic [7:0] mo, output logic [7:0] mi);
    for (int i = 7; i >= 0; i--) spi_bit(mo[i], mi[i]);
  endtask

  task automatic write_tx(input logic [7:0] d);
    tx_data = d; tx_valid = 1; ticks(1); tx_valid = 0;
  endtask

  task automatic read_rx();
    rx_ready = 1; ticks(1); rx_ready = 0;
  endtask

  task automatic clear_flags();
    stat_clr = 3'b111; ticks(1); stat_clr = 3'b000;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual 1 expected 0");
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] got, got2;
    logic dummy;
    rst_n = 0; en = 0; three_wire = 0; cpol = 0; cpha = 0; irq_en = 0;
    sck = 0; mosi = 0; nss = 1; tx_valid = 0; tx_data = 0; rx_ready = 0; stat_clr = 0;
    ticks(5); rst_n = 1; ticks(2);

    // R1 reset state
    check(tx_ready == 1, "R1 tx_ready", tx_ready, 1);
    check(rx_valid == 0, "R1 rx_valid", rx_valid, 0);
    check(stat_flags == 0, "R1 flags", stat_flags, 0);
    check(irq == 0 && miso == 0, "R1 irq/miso", {irq, miso}, 0);

    // R2 R3 R6: all four modes
    for (int m = 0; m < 4; m++) begin
      set_mode(0, m[1], m[0]);
      write_tx(8'hA5 ^ 8'(m));
      nss = 0; ticks(4);
      spi_byte(8'h3C + 8'(m), got);
      ticks(H); nss = 1; ticks(4);
      check(got == (8'hA5 ^ 8'(m)), "R3 miso byte", got, 8'hA5 ^ 8'(m));
      check(rx_valid && rx_data == 8'h3C + 8'(m), "R2 rx byte", rx_data, 8'h3C + 8'(m));
      check(stat_flags[0] == 1, "R6 done flag", stat_flags, 1);
      ticks(20);
      check(stat_flags[0] == 1, "R9 sticky done", stat_flags, 1);
      read_rx(); clear_flags();
    end

    // R4: lock at first edge, late beat waits for next byte
    set_mode(0, 0, 0);
    write_tx(8'h11); ticks(2);
    nss = 0; ticks(4);
    for (int i = 7; i >= 6; i--) spi_bit(1'b0, got[i]);
    write_tx(8'h22); ticks(1);
    check(tx_ready == 0, "R4 late beat held", tx_ready, 0);
    for (int i = 5; i >= 0; i--) spi_bit(1'b0, got[i]);
    check(got == 8'h11, "R4 locked byte", got, 8'h11);
    ticks(H);
    check(tx_ready == 1, "R4 latch moved after byte", tx_ready, 1);
    spi_byte(8'h00, got);
    check(got == 8'h22, "R4 held byte sent next", got, 8'h22);
    spi_byte(8'h00, got);
    check(got == 8'h00, "R4 empty sends zero", got, 0);
    ticks(H); nss = 1; ticks(4);
    read_rx(); clear_flags();

    // R5 collision, R9 irq and clear, R7 overrun
    write_tx(8'h33); ticks(2);
    write_tx(8'h44); ticks(1);
    check(tx_ready == 0, "R5 latch full", tx_ready, 0);
    write_tx(8'h55); ticks(1);
    check(stat_flags[1] == 1, "R5 collision flag", stat_flags, 3'b010);
    check(irq == 0, "R9 irq masked", irq, 0);
    irq_en = 1; ticks(1);
    check(irq == 1, "R9 irq raised", irq, 1);
    stat_clr = 3'b010; ticks(1); stat_clr = 0; ticks(1);
    check(stat_flags == 0 && irq == 0, "R9 cleared", {stat_flags, irq}, 0);
    irq_en = 0;
    nss = 0; ticks(4);
    spi_byte(8'h81, got);
    spi_byte(8'h7E, got2);
    ticks(H); nss = 1; ticks(4);
    check(got == 8'h33 && got2 == 8'h44, "R5 dropped beat not sent", {got, got2}, 16'h3344);
    check(rx_data == 8'h81, "R7 old byte kept", rx_data, 8'h81);
    check(stat_flags[2] == 1, "R7 overrun flag", stat_flags, 3'b101);
    read_rx(); ticks(1);
    check(rx_valid == 0, "R8 read empties", rx_valid, 0);
    clear_flags();

    // R8 read in the completion cycle
    set_mode(0, 0, 1);
    nss = 0; ticks(4);
    spi_byte(8'h12, got); ticks(6);
    spi_byte(8'h34, got);
    ticks(2); rx_ready = 1; ticks(1); rx_ready = 0; ticks(3);
    check(rx_valid && rx_data == 8'h34, "R8 same-cycle store", rx_data, 8'h34);
    check(stat_flags[2] == 0, "R8 no overrun", stat_flags[2], 0);
    nss = 1; ticks(4);
    read_rx(); clear_flags();

    // R10 four-wire select behaviour
    set_mode(0, 0, 0);
    nss = 0; ticks(4);
    for (int i = 0; i < 3; i++) spi_bit(1'b1, dummy);
    nss = 1; ticks(4);
    for (int i = 0; i < 8; i++) spi_bit(1'b1, dummy);
    ticks(4);
    check(stat_flags == 0 && rx_valid == 0, "R10 ignored while deselected", {stat_flags, rx_valid}, 0);
    check(miso_oe == 0 && miso == 0, "R3 not driven when deselected", {miso_oe, miso}, 0);
    nss = 0; ticks(4);
    spi_byte(8'h96, got); ticks(H + 4);
    check(rx_data == 8'h96, "R10 realigned byte", rx_data, 8'h96);
    nss = 1; ticks(4);
    read_rx(); clear_flags();

    // R11 three-wire
    set_mode(1, 0, 0);
    check(miso_oe == 1, "R11 driven with NSS high", miso_oe, 1);
    spi_byte(8'hC3, got); ticks(H + 4);
    check(rx_data == 8'hC3, "R11 byte with NSS high", rx_data, 8'hC3);
    read_rx(); clear_flags();
    spi_bit(1, dummy); spi_bit(0, dummy); spi_bit(1, dummy);
    nss = 0; ticks(4); nss = 1; ticks(4);
    spi_bit(1, dummy); spi_bit(1, dummy); spi_bit(0, dummy); spi_bit(0, dummy); spi_bit(1, dummy);
    ticks(H + 4);
    check(rx_data == 8'hB9 && stat_flags[0], "R11 NSS pulse ignored", rx_data, 8'hB9);
    read_rx(); clear_flags();

    // R12 enable toggle realigns, disabled ignores SCK
    for (int i = 0; i < 3; i++) spi_bit(1'b0, dummy);
    en = 0; ticks(4); en = 1; ticks(4);
    spi_byte(8'h5A, got); ticks(H + 4);
    check(rx_data == 8'h5A, "R12 realigned by enable", rx_data, 8'h5A);
    read_rx(); clear_flags();
    set_mode(0, 0, 0);
    en = 0; nss = 0; ticks(4);
    for (int i = 0; i < 8; i++) spi_bit(1'b1, dummy);
    ticks(6);
    check(stat_flags == 0 && rx_valid == 0, "R12 disabled ignores SCK", {stat_flags, rx_valid}, 0);
    nss = 1; ticks(4);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule